// File: doc/BRIEF.md
# Multiplying Angle-to-Resolver/Synchro Generator

This block turns a 16-bit binary angle and a signed reference sample into digital line values for a resolver or a three-wire synchro. A new conversion starts with a valid/ready handshake. The block captures the angle and the reference sample at acceptance. An iterative CORDIC then computes sine and cosine, and each trigonometric term is scaled by the captured reference sample. The reference may be any waveform: DC, a sine, or a sawtooth. A DC reference gives static sine/cosine values. A sawtooth reference applied to a fixed angle gives a radial sweep.

A static mode input selects one of two output mappings:
- **Resolver:** two lines carry reference·sin θ and reference·cos θ.
- **Synchro:** a linear recombination of the same sine and cosine yields three line-to-line values spaced 120 degrees apart.

All three outputs update in the same cycle, marked by a one-cycle done pulse. Between conversions the outputs hold their values.

Top module: `angle_resolver_gen`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0 and all three line outputs are 0.
- R2: `in_angle` is an unsigned fraction of a full turn: code k means k·360/65536 degrees, so 0x4000 is 90°, 0x8000 is 180° and 0xC000 is 270°.
- R3: With `mode_synchro` = 0 (resolver), `line_a` = ref·sin θ and `line_b` = ref·cos θ, each within 4 LSB of the ideal rounded value, and `line_c` = 0.
- R4: With `mode_synchro` = 1 (synchro), `line_a` = ref·sin θ, `line_b` = ref·sin(θ+120°) and `line_c` = ref·sin(θ+240°), each within 4 LSB.
- R5: The reference is a signed two's-complement sample with no offset removal. A zero reference gives exactly 0 on every line. A negative reference inverts the sign of every line. A ramp of references at a fixed angle gives outputs that follow the ramp.
- R6: Each product is rounded and then saturated to the signed 16-bit range. For example, ref −32768 at 270° in resolver mode gives `line_a` = 32767; the value does not wrap.
- R7: `in_ready` is 1 only while no conversion is in progress. A request is taken on a clock edge where both `in_valid` and `in_ready` are 1. `in_valid` asserted while `in_ready` is 0 is ignored: it produces no result, and the pending result is unchanged.
- R8: `done` rises exactly ITER+1 clock edges (17 by default) after the accepting edge. All three lines change only in a cycle where `done` is 1, and they hold between done pulses.
- R9: In resolver mode with a full-scale reference, sqrt(line_a² + line_b²) stays within 0.1% of |ref| at every angle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_synchro | input | 1 | Static mode select: 0 resolver, 1 synchro |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block can accept a request |
| in_angle | input | AW (16) | Binary fraction of a turn |
| in_ref | input | DW (16) | Signed reference sample |
| done | output | 1 | One-cycle pulse when the lines update |
| line_a | output | DW (16) | Signed line value: sine term |
| line_b | output | DW (16) | Signed line value: cosine, or the +120° term |
| line_c | output | DW (16) | Signed line value: zero, or the +240° term |

## Verification
The bench builds the block with its default parameters: 16-bit angle and data, 16 CORDIC iterations and a 20-bit internal datapath. With these values the expected line values can be computed with real arithmetic and compared to a 4 LSB tolerance. The 17-cycle latency can be checked cycle-exactly. Angles on and between every octant boundary exercise the quadrant fold. A reference of −32768 at a ±1 trigonometric term reaches the saturation corner. A reference ramp at a fixed angle checks the DC-coupled multiply.

// File: rtl/angle_res_pkg.sv
`timescale 1ns/1ps
package angle_res_pkg;
   // Phase accumulator: 2^20 counts per full turn, 2 extra bits for sign and headroom
   localparam int ARS_ATAN_FRAC = 20;
   localparam int ARS_ZW        = ARS_ATAN_FRAC + 2;
   localparam int ARS_ATAN_N    = 16;

   typedef enum logic {ARS_RESOLVER = 1'b0, ARS_SYNCHRO = 1'b1} ars_mode_e;
   typedef logic signed [ARS_ZW-1:0] ars_phase_t;

   // arctan(2^-i) expressed in 2^-20 turns
   function automatic ars_phase_t ars_atan(input logic [7:0] idx);
      case (idx)
         8'd0:    return ars_phase_t'(131072);
         8'd1:    return ars_phase_t'(77376);
         8'd2:    return ars_phase_t'(40884);
         8'd3:    return ars_phase_t'(20753);
         8'd4:    return ars_phase_t'(10417);
         8'd5:    return ars_phase_t'(5213);
         8'd6:    return ars_phase_t'(2607);
         8'd7:    return ars_phase_t'(1304);
         8'd8:    return ars_phase_t'(652);
         8'd9:    return ars_phase_t'(326);
         8'd10:   return ars_phase_t'(163);
         8'd11:   return ars_phase_t'(81);
         8'd12:   return ars_phase_t'(41);
         8'd13:   return ars_phase_t'(20);
         8'd14:   return ars_phase_t'(10);
         8'd15:   return ars_phase_t'(5);
         default: return '0;
      endcase
   endfunction
endpackage

// File: rtl/ars_fold.sv
`timescale 1ns/1ps
module ars_fold
   import angle_res_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [AW-1:0] angle_i,
   output ars_phase_t    phase_o,
   output logic          flip_o
);
   localparam int SH = ARS_ATAN_FRAC - AW;

   logic [AW-1:0] folded;

   // Angles in the second and third quadrant are moved by half a turn;
   // the resulting sign inversion is undone after the rotation.
   always_comb begin
      flip_o = angle_i[AW-1] ^ angle_i[AW-2];
      folded = flip_o ? {~angle_i[AW-1], angle_i[AW-2:0]} : angle_i;
      phase_o = ars_phase_t'({{(ARS_ZW-AW){folded[AW-1]}}, folded}) <<< SH;
   end
endmodule

// File: rtl/ars_cordic.sv
`timescale 1ns/1ps
module ars_cordic
   import angle_res_pkg::*;
#(
   parameter int ITER = 16,
   parameter int IW   = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  ars_phase_t           phase_i,
   input  logic                 flip_i,
   output logic                 busy,
   output logic                 fin,
   output logic signed [IW-1:0] sin_o,
   output logic signed [IW-1:0] cos_o
);
   localparam int FRAC = IW - 2;
   localparam int CW   = $clog2(ITER + 1);
   localparam logic signed [IW-1:0] X0  = IW'(int'(0.6072529350088813 * real'(1 << FRAC)));
   localparam logic signed [IW-1:0] LIM = IW'((1 << FRAC) + 256);

   logic signed [IW-1:0] x_q, y_q, xs, ys;
   ars_phase_t           z_q, da;
   logic [CW-1:0]        cnt_q;
   logic                 run_q, fin_q, flip_q;

   always_comb begin
      xs = x_q >>> cnt_q;
      ys = y_q >>> cnt_q;
      da = ars_atan(8'(cnt_q));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0; y_q <= '0; z_q <= '0;
         cnt_q <= '0; run_q <= 1'b0; fin_q <= 1'b0; flip_q <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (start) begin
            x_q    <= X0;
            y_q    <= '0;
            z_q    <= phase_i;
            flip_q <= flip_i;
            cnt_q  <= '0;
            run_q  <= 1'b1;
         end else if (run_q) begin
            if (!z_q[ARS_ZW-1]) begin
               x_q <= x_q - ys;
               y_q <= y_q + xs;
               z_q <= z_q - da;
            end else begin
               x_q <= x_q + ys;
               y_q <= y_q - xs;
               z_q <= z_q + da;
            end
            if (cnt_q == CW'(ITER - 1)) begin
               run_q <= 1'b0;
               fin_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign busy  = run_q | fin_q;
   assign fin   = fin_q;
   assign sin_o = flip_q ? -y_q : y_q;
   assign cos_o = flip_q ? -x_q : x_q;

   // R9
   mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (x_q <= LIM && x_q >= -LIM && y_q <= LIM && y_q >= -LIM));
endmodule

// File: rtl/ars_scale.sv
`timescale 1ns/1ps
module ars_scale #(
   parameter int IW   = 20,
   parameter int DW   = 16,
   parameter int FRAC = 18
) (
   input  logic signed [IW-1:0] term_i,
   input  logic signed [DW-1:0] ref_i,
   output logic signed [DW-1:0] val_o
);
   localparam int PW = IW + DW;
   localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);
   localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   logic signed [PW-1:0] prod, rnd, shf;

   always_comb begin
      prod = {{DW{term_i[IW-1]}}, term_i} * {{IW{ref_i[DW-1]}}, ref_i};
      rnd  = prod + HALF;
      shf  = rnd >>> FRAC;
      if (shf > MAXV)      val_o = MAXV[DW-1:0];
      else if (shf < MINV) val_o = MINV[DW-1:0];
      else                 val_o = shf[DW-1:0];
   end
endmodule

// File: rtl/ars_mix.sv
`timescale 1ns/1ps
module ars_mix
   import angle_res_pkg::*;
#(
   parameter int IW = 20,
   parameter int DW = 16
) (
   input  logic signed [IW-1:0] sin_i,
   input  logic signed [IW-1:0] cos_i,
   input  logic signed [DW-1:0] ref_i,
   input  ars_mode_e            mode_i,
   output logic [2:0][DW-1:0]   lane_o
);
   localparam int FRAC = IW - 2;
   localparam logic signed [IW-1:0] RT3H = IW'(int'(0.8660254037844386 * real'(1 << FRAC)));

   logic signed [2*IW-1:0] kc_w;
   logic signed [IW-1:0]   kc, half;
   logic signed [IW-1:0]   term [3];

   always_comb begin
      kc_w = {{IW{cos_i[IW-1]}}, cos_i} * {{IW{RT3H[IW-1]}}, RT3H};
      kc   = kc_w[FRAC+IW-1:FRAC];
      half = sin_i >>> 1;
      term[0] = sin_i;
      if (mode_i == ARS_SYNCHRO) begin
         term[1] = kc - half;
         term[2] = -kc - half;
      end else begin
         term[1] = cos_i;
         term[2] = '0;
      end
   end

   for (genvar g = 0; g < 3; g++) begin : g_lane
      logic signed [DW-1:0] v;
      ars_scale #(.IW(IW), .DW(DW), .FRAC(FRAC)) u_scale (
         .term_i (term[g]),
         .ref_i  (ref_i),
         .val_o  (v)
      );
      assign lane_o[g] = v;
   end
endmodule

// File: rtl/angle_resolver_gen.sv
`timescale 1ns/1ps
module angle_resolver_gen
   import angle_res_pkg::*;
#(
   parameter int AW   = 16,
   parameter int DW   = 16,
   parameter int ITER = 16,
   parameter int IW   = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_synchro,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [AW-1:0]        in_angle,
   input  logic signed [DW-1:0] in_ref,
   output logic                 done,
   output logic signed [DW-1:0] line_a,
   output logic signed [DW-1:0] line_b,
   output logic signed [DW-1:0] line_c
);
   localparam int LAT = ITER + 1;

   if (ITER < 1 || ITER > ARS_ATAN_N) begin : g_bad_iter
      $error("ITER must lie between 1 and %0d", ARS_ATAN_N);
   end
   if (AW < 4 || AW > ARS_ATAN_FRAC) begin : g_bad_aw
      $error("AW must lie between 4 and %0d", ARS_ATAN_FRAC);
   end
   if (IW < 12 || IW > 30) begin : g_bad_iw
      $error("IW must lie between 12 and 30");
   end
   if (DW < 4 || DW > 32) begin : g_bad_dw
      $error("DW must lie between 4 and 32");
   end

   ars_mode_e            mode_e;
   ars_phase_t           phase;
   logic                 flip, accept, busy, fin;
   logic signed [IW-1:0] sin_v, cos_v;
   logic signed [DW-1:0] ref_q;
   logic [2:0][DW-1:0]   lanes;

   assign mode_e   = ars_mode_e'(mode_synchro);
   assign in_ready = !busy;
   assign accept   = in_valid && in_ready;

   ars_fold #(.AW(AW)) u_fold (
      .angle_i (in_angle),
      .phase_o (phase),
      .flip_o  (flip)
   );

   ars_cordic #(.ITER(ITER), .IW(IW)) u_cordic (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .phase_i (phase),
      .flip_i  (flip),
      .busy    (busy),
      .fin     (fin),
      .sin_o   (sin_v),
      .cos_o   (cos_v)
   );

   ars_mix #(.IW(IW), .DW(DW)) u_mix (
      .sin_i  (sin_v),
      .cos_i  (cos_v),
      .ref_i  (ref_q),
      .mode_i (mode_e),
      .lane_o (lanes)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         done   <= 1'b0;
         line_a <= '0;
         line_b <= '0;
         line_c <= '0;
      end else begin
         if (accept) ref_q <= in_ref;
         done <= fin;
         if (fin) begin
            line_a <= lanes[0];
            line_b <= lanes[1];
            line_c <= lanes[2];
         end
      end
   end

   // Latency watch: counts edges since the accepting edge
   logic [7:0] lat_cnt;
   logic       lat_pend;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_cnt  <= '0;
         lat_pend <= 1'b0;
      end else if (accept) begin
         lat_cnt  <= '0;
         lat_pend <= 1'b1;
      end else if (lat_pend) begin
         lat_cnt <= lat_cnt + 1'b1;
         if (done) lat_pend <= 1'b0;
      end
   end

   // R8
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_pend && lat_cnt == 8'(LAT)));
   // R8
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(line_a) && $stable(line_b) && $stable(line_c)));
   // R7
   ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
   // R3
   resolver_c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mode_synchro) |-> (line_c == '0));
   // R5
   zero_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ref_q == '0) |-> (line_a == '0 && line_b == '0 && line_c == '0));
endmodule

// File: tb/test_angle_resolver_gen.sv
`timescale 1ns/1ps
module test_angle_resolver_gen;
   localparam real PI  = 3.14159265358979323846;
   localparam int  LAT = 17;
   localparam int  TOL = 4;

   typedef struct {
      int    ea, eb, ec;
      int    due;
      int    refv;
      bit    mag;
      string tag;
   } exp_t;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               mode_synchro = 1'b0;
   logic               in_valid = 1'b0;
   logic               in_ready, done;
   logic [15:0]        in_angle = '0;
   logic signed [15:0] in_ref = '0;
   logic signed [15:0] line_a, line_b, line_c;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   int   hold_bad = 0;
   int   la, lb, lc;
   exp_t q[$];

   always #2.5 clk = ~clk;

   angle_resolver_gen i_angle_resolver_gen (
      .clk, .rst_n, .mode_synchro, .in_valid, .in_ready, .in_angle, .in_ref,
      .done, .line_a, .line_b, .line_c
   );

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic int rnd_sat(input real p);
      int r;
      r = (p >= 0.0) ? $rtoi(p + 0.5) : -$rtoi(-p + 0.5);
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return r;
   endfunction

   function automatic int absi(input int v);
      return (v < 0) ? -v : v;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         chk(1'b0, "watchdog expired", cyc, 100000);
         finish_run();
      end
   end

   // Driver: compute the ideal line values and push them on the scoreboard
   task automatic send(input logic [15:0] ang, input int refv, input string tag, input bit mag);
      exp_t e;
      real  th;
      th = 2.0 * PI * real'(ang) / 65536.0;
      e.ea = rnd_sat(real'(refv) * $sin(th));
      if (mode_synchro) begin
         e.eb = rnd_sat(real'(refv) * $sin(th + 2.0 * PI / 3.0));
         e.ec = rnd_sat(real'(refv) * $sin(th + 4.0 * PI / 3.0));
      end else begin
         e.eb = rnd_sat(real'(refv) * $cos(th));
         e.ec = 0;
      end
      e.refv = refv;
      e.mag  = mag;
      e.tag  = tag;
      @(negedge clk);
      in_valid = 1'b1;
      in_angle = ang;
      in_ref   = 16'(refv);
      while (!in_ready) @(negedge clk);
      e.due = cyc + 1 + LAT;
      q.push_back(e);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: pop and compare when the lines update
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (q.size() == 0) begin
               chk(1'b0, "R7 done without accepted request", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(absi(int'(line_a) - e.ea) <= TOL, {e.tag, " line_a"}, int'(line_a), e.ea);
               chk(absi(int'(line_b) - e.eb) <= TOL, {e.tag, " line_b"}, int'(line_b), e.eb);
               chk(absi(int'(line_c) - e.ec) <= TOL, {e.tag, " line_c"}, int'(line_c), e.ec);
               chk(cyc == e.due, "R8 done latency (cycle)", cyc, e.due);
               if (e.mag) begin
                  real m;
                  m = $sqrt(real'(line_a) * real'(line_a) + real'(line_b) * real'(line_b));
                  chk((m - real'(absi(e.refv))) <= 0.001 * real'(absi(e.refv)) &&
                      (real'(absi(e.refv)) - m) <= 0.001 * real'(absi(e.refv)),
                      "R9 resolver magnitude", $rtoi(m), absi(e.refv));
               end
            end
            la = int'(line_a); lb = int'(line_b); lc = int'(line_c);
         end else if (int'(line_a) != la || int'(line_b) != lb || int'(line_c) != lc) begin
            hold_bad++;
         end
      end
   end

   initial begin
      la = 0; lb = 0; lc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);
      chk(line_a == 0 && line_b == 0 && line_c == 0, "R1 lines after reset",
          int'(line_a) | int'(line_b) | int'(line_c), 0);

      // R2 R3: resolver at every octant boundary and in between
      mode_synchro = 1'b0;
      for (int k = 0; k < 8; k++) send(16'(k * 16'h2000), 20000, "R2 R3 octant", 1'b0);
      send(16'h1555, -12345, "R3 negative ref", 1'b0);
      send(16'hFFFF, 30000, "R2 R3 last code", 1'b0);
      send(16'h6A3C, 17777, "R3 second quadrant", 1'b0);
      // R9 magnitude at full scale
      send(16'h1555, 32767, "R9 R3", 1'b1);
      send(16'h3FFF, 32767, "R9 R3", 1'b1);
      send(16'h9876, 32767, "R9 R3", 1'b1);
      send(16'hD1A0, 32767, "R9 R3", 1'b1);
      // R6 saturation corners
      send(16'hC000, -32768, "R6 saturate positive", 1'b0);
      send(16'h8000, -32768, "R6 saturate cos", 1'b0);
      send(16'h4000, 32767, "R6 full scale", 1'b0);
      // R5 zero reference and DC-coupled ramp
      send(16'h2345, 0, "R5 zero ref", 1'b0);
      for (int r = -30000; r <= 30000; r += 6000) send(16'h2000, r, "R5 ramp", 1'b0);

      // R7: requests while busy are ignored
      send(16'h1000, 15000, "R7 first request", 1'b0);
      in_valid = 1'b1; in_angle = 16'h7777; in_ref = 16'sd999;
      repeat (4) @(negedge clk);
      chk(in_ready == 1'b0, "R7 in_ready low while busy", int'(in_ready), 0);
      in_valid = 1'b0;
      drain();
      chk(in_ready == 1'b1, "R7 in_ready back when idle", int'(in_ready), 1);

      // R4: synchro mapping
      mode_synchro = 1'b1;
      @(negedge clk);
      send(16'h0000, 25000, "R4 synchro", 1'b0);
      send(16'h4000, -32768, "R4 R6 synchro", 1'b0);
      send(16'h2AAA, 30000, "R4 synchro", 1'b0);
      send(16'h5555, 30000, "R4 synchro", 1'b0);
      send(16'hB000, -21000, "R4 synchro", 1'b0);
      send(16'hE123, 32767, "R4 synchro", 1'b0);
      send(16'h8000, 0, "R4 R5 synchro zero", 1'b0);
      drain();

      // R8: lines held between done pulses
      chk(hold_bad == 0, "R8 lines changed outside done", hold_bad, 0);
      chk(q.size() == 0, "R7 results outstanding", q.size(), 0);
      finish_run();
   end
endmodule